// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block holds the instruction fetch address of a small 8-bit controller and keeps its subroutine return addresses. Program space is 4096 words, split into four pages of 1024 words. The page is chosen by the top two address bits. Every cycle the decoder presents one operation class for the instruction now at `pc_o`. With it come a 10-bit immediate target, the 8-bit accumulator and the two page bits from the status register. The block then computes the next fetch address.

Any taken change of flow costs one extra instruction cycle. For the cycle after such an operation the block raises `stall_o`. During that cycle it holds the address it has just loaded and ignores the operation inputs. Jumps, calls and writes to the low address register all take their page from `page_i`. Direct writes and adds to the low register clear address bits 9..8. The table form keeps bits 9..8, so it can reach any 256-word quarter of the current page.

Return addresses go into a small circular stack. When the stack is full, a new push replaces the oldest entry. Popping past the last valid entry keeps cycling through the slots and raises no flag.

Top module: `pgpc_core`

## Requirements
- R1: While `rst_ni` is low, `pc_o` is 0xFFF and `stall_o` is 0. This also applies when reset is asserted just after a flow change.
- R2: With `op_i` = 0 (sequential) or 7 (treated as sequential) and no stall, `pc_o` becomes `pc_o`+1 modulo 4096. So 0xFFF is followed by 0x000.
- R3: With `op_i` = 1 (jump) and no stall, `pc_o` becomes {`page_i`, `imm_i`}.
- R4: With `op_i` = 2 (call) and no stall, `pc_o` becomes {`page_i`, `imm_i`} and `pc_o`+1 is pushed onto the stack.
- R5: With `op_i` = 3 (return) and no stall, `pc_o` becomes the top stack entry and that entry is popped.
- R6: With `op_i` = 4 (move to low register) and no stall, `pc_o` becomes {`page_i`, 2'b00, `acc_i`}.
- R7: With `op_i` = 5 (add to low register) and no stall, `pc_o` becomes {`page_i`, 2'b00, (`pc_o`[7:0]+`acc_i`) mod 256}. The carry out is dropped.
- R8: With `op_i` = 6 (table add) and no stall, `pc_o` becomes {`page_i`, `pc_o`[9:8], (`pc_o`[7:0]+`acc_i`) mod 256}. Bits 9..8 are kept and the carry is dropped.
- R9: Any of `op_i` = 1..6 taken without a stall raises `stall_o` for exactly the next cycle. A sequential operation never raises it.
- R10: While `stall_o` is high, `op_i`, `imm_i`, `acc_i` and `page_i` are ignored and `pc_o` holds.
- R11: The stack holds 5 entries. A sixth push overwrites the oldest entry. After five pops, a further pop continues around the ring and returns the most recent surviving slot again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation class of the instruction at `pc_o` |
| imm_i | input | 10 | In-page target for jump and call |
| acc_i | input | 8 | Accumulator value for low-register writes and adds |
| page_i | input | 2 | Page select from the status register |
| pc_o | output | 12 | Fetch address |
| stall_o | output | 1 | Extra instruction cycle after a taken flow change |

## Verification
The bench builds the block with its default parameters: a 12-bit address, a 2-bit page field, an 8-bit low byte and a 5-entry stack. With these values the address wrap from 0xFFF to 0x000 is reached straight out of reset, and a table add across a byte boundary shows that the carry is dropped. Six nested calls are enough to overwrite the oldest return address. Six returns then show the ring wrapping on underflow.

// File: rtl/pgpc_pkg.sv
package pgpc_pkg;

  typedef enum logic [2:0] {
    OP_SEQ  = 3'd0,
    OP_JMP  = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_MOVL = 3'd4,
    OP_ADDL = 3'd5,
    OP_TBL  = 3'd6,
    OP_NOP7 = 3'd7
  } pc_op_e;

  function automatic logic op_is_flow(input logic [2:0] op);
    return (op != OP_SEQ) && (op != OP_NOP7);
  endfunction

endpackage

// File: rtl/pgpc_target.sv
module pgpc_target
  import pgpc_pkg::*;
#(
  parameter int PC_W   = 12,
  parameter int PAGE_W = 2,
  parameter int BYTE_W = 8
) (
  input  logic [PC_W-1:0]        pc_i,
  input  logic [2:0]             op_i,
  input  logic [PC_W-PAGE_W-1:0] imm_i,
  input  logic [BYTE_W-1:0]      acc_i,
  input  logic [PAGE_W-1:0]      page_i,
  input  logic [PC_W-1:0]        top_i,
  output logic [PC_W-1:0]        nxt_o,
  output logic [PC_W-1:0]        ret_addr_o
);

  localparam int LOW_W = PC_W - PAGE_W;
  localparam int MID_W = LOW_W - BYTE_W;

  logic [BYTE_W-1:0] byte_sum;
  logic [PC_W-1:0]   inc_pc;

  assign byte_sum   = pc_i[BYTE_W-1:0] + acc_i;
  assign inc_pc     = pc_i + PC_W'(1);
  assign ret_addr_o = inc_pc;

  always_comb begin
    nxt_o = inc_pc;
    unique case (op_i)
      OP_JMP,
      OP_CALL: nxt_o = {page_i, imm_i};
      OP_RET:  nxt_o = top_i;
      OP_MOVL: nxt_o = {page_i, {MID_W{1'b0}}, acc_i};
      OP_ADDL: nxt_o = {page_i, {MID_W{1'b0}}, byte_sum};
      OP_TBL:  nxt_o = {page_i, pc_i[LOW_W-1:BYTE_W], byte_sum};
      default: nxt_o = inc_pc;
    endcase
  end

endmodule

// File: rtl/pgpc_stack.sv
module pgpc_stack #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic [DATA_W-1:0] top_o
);

  localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [SP_W-1:0] LAST = SP_W'(DEPTH - 1);

  logic [SP_W-1:0]   sp_q, sp_d;
  logic [SP_W-1:0]   rd_idx;
  logic [DATA_W-1:0] slot_q [DEPTH];

  assign rd_idx = (sp_q == '0) ? LAST : (sp_q - SP_W'(1));
  assign top_o  = slot_q[rd_idx];

  always_comb begin
    sp_d = sp_q;
    if (push_i) begin
      sp_d = (sp_q == LAST) ? '0 : (sp_q + SP_W'(1));
    end else if (pop_i) begin
      sp_d = rd_idx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= '0;
    end else if (push_i || pop_i) begin
      sp_q <= sp_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic wr_en;
    assign wr_en = push_i && (sp_q == SP_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q[g] <= '0;
      end else if (wr_en) begin
        slot_q[g] <= push_data_i;
      end
    end
  end

endmodule

// File: rtl/pgpc_core.sv
module pgpc_core
  import pgpc_pkg::*;
#(
  parameter int PC_W   = 12,
  parameter int PAGE_W = 2,
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [2:0]             op_i,
  input  logic [PC_W-PAGE_W-1:0] imm_i,
  input  logic [BYTE_W-1:0]      acc_i,
  input  logic [PAGE_W-1:0]      page_i,
  output logic [PC_W-1:0]        pc_o,
  output logic                   stall_o
);

  logic [PC_W-1:0] pc_q, pc_d;
  logic            stall_q, stall_d;
  logic            act;
  logic            push, pop;
  logic [PC_W-1:0] nxt_pc, ret_addr, top;

  assign act  = !stall_q;
  assign push = act && (op_i == OP_CALL);
  assign pop  = act && (op_i == OP_RET);

  pgpc_target #(
    .PC_W  (PC_W),
    .PAGE_W(PAGE_W),
    .BYTE_W(BYTE_W)
  ) u_target (
    .pc_i      (pc_q),
    .op_i      (op_i),
    .imm_i     (imm_i),
    .acc_i     (acc_i),
    .page_i    (page_i),
    .top_i     (top),
    .nxt_o     (nxt_pc),
    .ret_addr_o(ret_addr)
  );

  pgpc_stack #(
    .DATA_W(PC_W),
    .DEPTH (DEPTH)
  ) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .pop_i      (pop),
    .push_data_i(ret_addr),
    .top_o      (top)
  );

  always_comb begin
    pc_d    = pc_q;
    stall_d = 1'b0;
    if (act) begin
      pc_d    = nxt_pc;
      stall_d = op_is_flow(op_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '1;
      stall_q <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      stall_q <= stall_d;
    end
  end

  assign pc_o    = pc_q;
  assign stall_o = stall_q;

endmodule

// File: rtl/pgpc_core_chk.sv
module pgpc_core_chk
  import pgpc_pkg::*;
#(
  parameter int PC_W   = 12,
  parameter int PAGE_W = 2,
  parameter int BYTE_W = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [2:0]             op_i,
  input logic [PC_W-PAGE_W-1:0] imm_i,
  input logic [PAGE_W-1:0]      page_i,
  input logic [PC_W-1:0]        pc_o,
  input logic                   stall_o
);

  localparam int LOW_W = PC_W - PAGE_W;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      // R1
      reset_state_chk: assert (pc_o == '1 && !stall_o);
    end
  end

  // R2
  seq_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && !op_is_flow(op_i)) |=> (pc_o == ($past(pc_o) + PC_W'(1))));

  // R3
  jmp_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && op_i == OP_JMP) |=> (pc_o == {$past(page_i), $past(imm_i)}));

  // R6
  low_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && (op_i == OP_MOVL || op_i == OP_ADDL)) |=> (pc_o[LOW_W-1:BYTE_W] == '0));

  // R8
  tbl_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && op_i == OP_TBL) |=>
      (pc_o[LOW_W-1:BYTE_W] == $past(pc_o[LOW_W-1:BYTE_W]) &&
       pc_o[PC_W-1:LOW_W] == $past(page_i)));

  // R9
  flow_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && op_is_flow(op_i)) |=> stall_o);

  // R9
  stall_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !stall_o);

  // R10
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> (pc_o == $past(pc_o)));

endmodule

bind pgpc_core pgpc_core_chk #(
  .PC_W  (PC_W),
  .PAGE_W(PAGE_W),
  .BYTE_W(BYTE_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .op_i   (op_i),
  .imm_i  (imm_i),
  .page_i (page_i),
  .pc_o   (pc_o),
  .stall_o(stall_o)
);

// File: tb/pgpc_core_tb.sv
module pgpc_core_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [2:0]  op_i;
  logic [9:0]  imm_i;
  logic [7:0]  acc_i;
  logic [1:0]  page_i;
  logic [11:0] pc_o;
  logic        stall_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  pgpc_core u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op_i),
    .imm_i  (imm_i),
    .acc_i  (acc_i),
    .page_i (page_i),
    .pc_o   (pc_o),
    .stall_o(stall_o)
  );

  // {op, imm, acc, page, expected pc, expected stall}
  localparam int NV = 16;
  localparam logic [35:0] VEC [NV] = '{
    {3'd0, 10'h000, 8'h00, 2'd0, 12'h000, 1'b0},
    {3'd0, 10'h000, 8'h00, 2'd0, 12'h001, 1'b0},
    {3'd1, 10'h155, 8'h00, 2'd2, 12'h955, 1'b1},
    {3'd1, 10'h3FF, 8'h77, 2'd3, 12'h955, 1'b0},
    {3'd2, 10'h2FE, 8'h00, 2'd1, 12'h6FE, 1'b1},
    {3'd0, 10'h000, 8'h00, 2'd0, 12'h6FE, 1'b0},
    {3'd0, 10'h000, 8'h00, 2'd0, 12'h6FF, 1'b0},
    {3'd6, 10'h000, 8'h05, 2'd1, 12'h604, 1'b1},
    {3'd0, 10'h000, 8'h00, 2'd0, 12'h604, 1'b0},
    {3'd5, 10'h000, 8'h10, 2'd3, 12'hC14, 1'b1},
    {3'd0, 10'h000, 8'h00, 2'd0, 12'hC14, 1'b0},
    {3'd4, 10'h000, 8'hAB, 2'd0, 12'h0AB, 1'b1},
    {3'd0, 10'h000, 8'h00, 2'd0, 12'h0AB, 1'b0},
    {3'd3, 10'h000, 8'h00, 2'd0, 12'h956, 1'b1},
    {3'd0, 10'h000, 8'h00, 2'd0, 12'h956, 1'b0},
    {3'd7, 10'h000, 8'h00, 2'd0, 12'h957, 1'b0}
  };

  function automatic string tag_of(input logic [2:0] op, input logic stalled);
    if (stalled) return "R10";
    case (op)
      3'd1:    return "R3";
      3'd2:    return "R4";
      3'd3:    return "R5";
      3'd4:    return "R6";
      3'd5:    return "R7";
      3'd6:    return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string req, input logic [11:0] exp_pc, input logic exp_st);
    n_chk++;
    if (pc_o !== exp_pc || stall_o !== exp_st) begin
      n_fail++;
      $display("FAIL %s: pc=%03h stall=%0b expected pc=%03h stall=%0b",
               req, pc_o, stall_o, exp_pc, exp_st);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [9:0] imm,
                      input logic [7:0] acc, input logic [1:0] pg);
    op_i   = op;
    imm_i  = imm;
    acc_i  = acc;
    page_i = pg;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_ni = 1'b1;
    op_i   = 3'd0;
    imm_i  = '0;
    acc_i  = '0;
    page_i = '0;
    #1 rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    check("R1", 12'hFFF, 1'b0);
    rst_ni = 1'b1;

    // Vector table: R2 wrap, R3, R10 ignore, R4, R8 carry, R7, R6, R5
    begin
      logic prev_st = 1'b0;
      for (int i = 0; i < NV; i++) begin
        logic [35:0] v;
        v = VEC[i];
        step(v[35:33], v[32:23], v[22:15], v[14:13]);
        check(tag_of(v[35:33], prev_st), v[12:1], v[0]);
        prev_st = v[0];
      end
    end

    // R9: one-cycle stall after a jump, none after a sequential step
    step(3'd1, 10'h100, 8'h00, 2'd0);
    check("R9", 12'h100, 1'b1);
    step(3'd0, 10'h000, 8'h00, 2'd0);
    check("R9", 12'h100, 1'b0);

    // R4 / R11: six nested calls into a five-entry stack
    for (int k = 0; k < 6; k++) begin
      step(3'd2, 10'(10'h200 + k), 8'h00, 2'd0);
      check("R4", 12'(12'h200 + k), 1'b1);
      step(3'd0, 10'h000, 8'h00, 2'd0);
    end
    // pushed: 101, 201, 202, 203, 204, 205 (101 overwritten)
    begin
      logic [11:0] exp_ret [6] = '{12'h205, 12'h204, 12'h203, 12'h202, 12'h201, 12'h205};
      for (int k = 0; k < 6; k++) begin
        step(3'd3, 10'h000, 8'h00, 2'd0);
        check("R11", exp_ret[k], 1'b1);
        step(3'd0, 10'h000, 8'h00, 2'd0);
      end
    end

    // R1: reset while a stall is pending
    step(3'd1, 10'h2AA, 8'h00, 2'd3);
    check("R3", 12'hEAA, 1'b1);
    rst_ni = 1'b0;
    #2;
    check("R1", 12'hFFF, 1'b0);
    @(posedge clk_i);
    @(negedge clk_i);
    check("R1", 12'hFFF, 1'b0);
    rst_ni = 1'b1;
    step(3'd0, 10'h000, 8'h00, 2'd0);
    check("R2", 12'h000, 1'b0);

    finish_run();
  end

endmodule